// File: doc/BRIEF.md
# Adder Operand and Register Load Control

This block sits beside the datapath adder and the PC, AC and MQ registers of a small word-oriented processor. It chooses what the data side of the adder receives: zero, the data bus, or the data bus complemented. It sets up the "memory address plus one" step that runs in the first time state. It also produces two single-cycle strobes. One is the shared register clock that loads the PC, AC or MQ. The other is the load strobe of the memory-address register.

The select outputs are combinational levels derived from the current time state, major state and instruction. The strobes are registered. A strobe goes low in the clock cycle that follows the triggering time pulse, bus strobe or manual load pulse, and lasts one cycle. All outputs are active low. A two-flop synchronizer releases the asynchronous reset.

Encodings used throughout: time state `ts` 0=TS1, 1=TS2, 2=TS3, 3=TS4. Major state `mstate` 0=Fetch, 1=Defer, 2=Execute, 3=DMA. Opcode `opcode` 0=AND, 1=TAD, 2=ISZ, 3=DCA, 4=JMS, 5=JMP, 6=IOT, 7=OPR.

Top module: `opnd_load_ctl`

## Requirements
- R1: The operand pair `{data_ena_n, data_cmp_n}` is 11 for zero, 00 for complemented data and 01 for true data. The pair 10 never appears. Outside R2 and R11, `cmp_req` high selects complemented data and low selects true data.
- R2: In TS1 (`ts`=0) the operand is zero.
- R3: `sel_addr_n` and `carry_en_n` are low exactly when `ts`=0 and `la_en_n` is high.
- R4: `pc_ld_en_n` is low exactly when `ts`=0, `la_en_n` is high and `mstate` is Fetch (0) or DMA (3).
- R5: `ma_load_n` is low in the cycle after a cycle in which `tp4` is high with `ld_inh_n` high, or `man_la` is high. It is high otherwise; `tp4` with `ld_inh_n` low has no effect.
- R6: `reg_clk_n` is low in the cycle after `tp1` is high in Fetch or DMA.
- R7: `reg_clk_n` is low in the cycle after `tp3` is high with opcode JMP (5) in Defer, or in Fetch with `ind` low. A JMP in Fetch with `ind` high gives no clock.
- R8: `reg_clk_n` is low in the cycle after `tp3` is high in Execute for JMS, DCA, TAD or AND. ISZ, IOT and OPR in Execute give no clock.
- R9: `reg_clk_n` is low in the cycle after `bus_strobe` is high with `iot_xfer` high. A bus strobe with `iot_xfer` low has no effect.
- R10: After reset both strobes are high. Each strobe is low only in cycles that directly follow a trigger, so a single trigger gives a one-cycle pulse.
- R11: In Execute (`mstate`=2) of DCA (`opcode`=3), outside TS1, the operand is zero whatever `cmp_req` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts | input | 2 | Current time state code |
| tp1 | input | 1 | Time pulse 1, one cycle |
| tp3 | input | 1 | Time pulse 3, one cycle |
| tp4 | input | 1 | Time pulse 4, one cycle |
| bus_strobe | input | 1 | Peripheral bus strobe |
| iot_xfer | input | 1 | IOT data transfer in progress |
| mstate | input | 2 | Major state code |
| opcode | input | 3 | Basic instruction code |
| ind | input | 1 | Indirect addressing bit of the instruction |
| cmp_req | input | 1 | Microinstruction asks for complemented data |
| la_en_n | input | 1 | Load-address enable, active low; blocks the increment |
| ld_inh_n | input | 1 | Address-register load inhibit, active low |
| man_la | input | 1 | Manual load-address pulse |
| data_ena_n | output | 1 | Operand select: data enable |
| data_cmp_n | output | 1 | Operand select: complement |
| sel_addr_n | output | 1 | Selects the address register onto the adder |
| carry_en_n | output | 1 | Carry-in enable |
| pc_ld_en_n | output | 1 | PC load enable |
| reg_clk_n | output | 1 | Shared PC/AC/MQ load strobe |
| ma_load_n | output | 1 | Memory-address register load strobe |

## Verification
Every cycle, the checker confirms these points. The forbidden operand pair never appears. The address-select and carry outputs only go low in TS1. The PC load enable never appears without the carry. Every strobe pulse traces back to a trigger in the cycle before it, and the Fetch/DMA time-pulse-1 and IOT bus-strobe triggers always give a clock. Some cases are not covered by those properties: the opcode-specific choices for TS3 (which JMP and Execute cases clock, and which do not), the zero operand for Execute DCA, and inputs that must have no effect. The bench covers these with its random and directed cycles and compares against an independent model.

// File: rtl/opld_pkg.sv
package opld_pkg;
  localparam int TS_W = 2;
  localparam int MS_W = 2;
  localparam int OP_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [MS_W-1:0] {
    MS_FETCH = 2'd0, MS_DEFER = 2'd1, MS_EXEC = 2'd2, MS_DMA = 2'd3
  } mstate_e;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    OPND_ZERO = 2'd0, OPND_TRUE = 2'd1, OPND_COMP = 2'd2
  } opnd_e;

  localparam logic [TS_W-1:0] TS1 = '0;
endpackage

// File: rtl/opnd_select.sv
module opnd_select
  import opld_pkg::*;
(
  input  logic [TS_W-1:0] ts,
  input  logic [MS_W-1:0] mstate,
  input  logic [OP_W-1:0] opcode,
  input  logic            cmp_req,
  output logic            data_ena_n,
  output logic            data_cmp_n
);
  opnd_e choice;

  always_comb begin
    if (ts == TS1)
      choice = OPND_ZERO;
    else if (mstate_e'(mstate) == MS_EXEC && opcode_e'(opcode) == OP_DCA)
      choice = OPND_ZERO;
    else if (cmp_req)
      choice = OPND_COMP;
    else
      choice = OPND_TRUE;
  end

  always_comb begin
    unique case (choice)
      OPND_COMP: begin data_ena_n = 1'b0; data_cmp_n = 1'b0; end
      OPND_TRUE: begin data_ena_n = 1'b0; data_cmp_n = 1'b1; end
      default:   begin data_ena_n = 1'b1; data_cmp_n = 1'b1; end
    endcase
  end
endmodule

// File: rtl/addr_step.sv
module addr_step
  import opld_pkg::*;
(
  input  logic [TS_W-1:0] ts,
  input  logic [MS_W-1:0] mstate,
  input  logic            la_en_n,
  output logic            sel_addr_n,
  output logic            carry_en_n,
  output logic            pc_ld_en_n
);
  logic step;
  logic pc_state;

  always_comb begin
    step     = (ts == TS1) && la_en_n;
    pc_state = (mstate_e'(mstate) == MS_FETCH) || (mstate_e'(mstate) == MS_DMA);
    sel_addr_n = ~step;
    carry_en_n = ~step;
    pc_ld_en_n = ~(step && pc_state);
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import opld_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tp1,
  input  logic            tp3,
  input  logic            tp4,
  input  logic            bus_strobe,
  input  logic            iot_xfer,
  input  logic [MS_W-1:0] mstate,
  input  logic [OP_W-1:0] opcode,
  input  logic            ind,
  input  logic            ld_inh_n,
  input  logic            man_la,
  output logic            reg_clk_n,
  output logic            ma_load_n
);
  logic    clk_fire_d, ma_fire_d;
  logic    clk_q, ma_q;
  logic    tp1_hit, tp3_hit, io_hit;
  mstate_e ms;
  opcode_e op;

  always_comb begin
    ms = mstate_e'(mstate);
    op = opcode_e'(opcode);
    tp1_hit = tp1 && (ms == MS_FETCH || ms == MS_DMA);
    tp3_hit = 1'b0;
    if (tp3) begin
      unique case (ms)
        MS_DEFER: tp3_hit = (op == OP_JMP);
        MS_FETCH: tp3_hit = (op == OP_JMP) && !ind;
        MS_EXEC:  tp3_hit = (op == OP_JMS) || (op == OP_DCA) ||
                            (op == OP_TAD) || (op == OP_AND);
        default:  tp3_hit = 1'b0;
      endcase
    end
    io_hit     = bus_strobe && iot_xfer;
    clk_fire_d = tp1_hit || tp3_hit || io_hit;
    ma_fire_d  = (tp4 && ld_inh_n) || man_la;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      ma_q  <= 1'b0;
    end else begin
      clk_q <= clk_fire_d;
      ma_q  <= ma_fire_d;
    end
  end

  assign reg_clk_n = ~clk_q;
  assign ma_load_n = ~ma_q;
endmodule

// File: rtl/opnd_load_ctl.sv
module opnd_load_ctl
  import opld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ts,
  input  logic       tp1,
  input  logic       tp3,
  input  logic       tp4,
  input  logic       bus_strobe,
  input  logic       iot_xfer,
  input  logic [1:0] mstate,
  input  logic [2:0] opcode,
  input  logic       ind,
  input  logic       cmp_req,
  input  logic       la_en_n,
  input  logic       ld_inh_n,
  input  logic       man_la,
  output logic       data_ena_n,
  output logic       data_cmp_n,
  output logic       sel_addr_n,
  output logic       carry_en_n,
  output logic       pc_ld_en_n,
  output logic       reg_clk_n,
  output logic       ma_load_n
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  opnd_select u_opnd (
    .ts(ts), .mstate(mstate), .opcode(opcode), .cmp_req(cmp_req),
    .data_ena_n(data_ena_n), .data_cmp_n(data_cmp_n)
  );

  addr_step u_step (
    .ts(ts), .mstate(mstate), .la_en_n(la_en_n),
    .sel_addr_n(sel_addr_n), .carry_en_n(carry_en_n), .pc_ld_en_n(pc_ld_en_n)
  );

  strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .tp1(tp1), .tp3(tp3), .tp4(tp4),
    .bus_strobe(bus_strobe), .iot_xfer(iot_xfer), .mstate(mstate),
    .opcode(opcode), .ind(ind), .ld_inh_n(ld_inh_n), .man_la(man_la),
    .reg_clk_n(reg_clk_n), .ma_load_n(ma_load_n)
  );
endmodule

// File: rtl/opnd_load_ctl_chk.sv
module opnd_load_ctl_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] ts,
  input logic       tp1,
  input logic       tp3,
  input logic       tp4,
  input logic       bus_strobe,
  input logic       iot_xfer,
  input logic [1:0] mstate,
  input logic       ld_inh_n,
  input logic       man_la,
  input logic       data_ena_n,
  input logic       data_cmp_n,
  input logic       sel_addr_n,
  input logic       carry_en_n,
  input logic       pc_ld_en_n,
  input logic       reg_clk_n,
  input logic       ma_load_n
);
  // R1
  no_bad_opnd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(data_ena_n && !data_cmp_n));
  // R3
  step_ts1_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_addr_n || !carry_en_n) |-> (ts == 2'd0));
  // R4
  pcld_needs_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pc_ld_en_n |-> !carry_en_n);
  // R5
  ma_load_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ma_load_n && $past(rst_sync_n)) |-> ($past(tp4 && ld_inh_n) || $past(man_la)));
  // R6
  tp1_clock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tp1 && (mstate == 2'd0 || mstate == 2'd3)) |=> !reg_clk_n);
  // R9
  iot_clock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_strobe && iot_xfer) |=> !reg_clk_n);
  // R10
  clk_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!reg_clk_n && $past(rst_sync_n)) |-> ($past(tp1) || $past(tp3) || $past(bus_strobe)));
endmodule

bind opnd_load_ctl opnd_load_ctl_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ts(ts), .tp1(tp1), .tp3(tp3), .tp4(tp4),
  .bus_strobe(bus_strobe), .iot_xfer(iot_xfer), .mstate(mstate),
  .ld_inh_n(ld_inh_n), .man_la(man_la), .data_ena_n(data_ena_n),
  .data_cmp_n(data_cmp_n), .sel_addr_n(sel_addr_n), .carry_en_n(carry_en_n),
  .pc_ld_en_n(pc_ld_en_n), .reg_clk_n(reg_clk_n), .ma_load_n(ma_load_n)
);

// File: tb/opnd_load_ctl_bench.sv
`timescale 1ns/1ps
module opnd_load_ctl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ts, mstate;
  logic [2:0] opcode;
  logic tp1, tp3, tp4, bus_strobe, iot_xfer, ind, cmp_req, la_en_n, ld_inh_n, man_la;
  logic data_ena_n, data_cmp_n, sel_addr_n, carry_en_n, pc_ld_en_n, reg_clk_n, ma_load_n;
  int total = 0;
  int bad = 0;
  logic exp_clk_q, exp_ma_q;
  string clk_tag;

  always #5 clk = ~clk;

  opnd_load_ctl u_opnd_load_ctl (
    .clk(clk), .rst_n(rst_n), .ts(ts), .tp1(tp1), .tp3(tp3), .tp4(tp4),
    .bus_strobe(bus_strobe), .iot_xfer(iot_xfer), .mstate(mstate), .opcode(opcode),
    .ind(ind), .cmp_req(cmp_req), .la_en_n(la_en_n), .ld_inh_n(ld_inh_n),
    .man_la(man_la), .data_ena_n(data_ena_n), .data_cmp_n(data_cmp_n),
    .sel_addr_n(sel_addr_n), .carry_en_n(carry_en_n), .pc_ld_en_n(pc_ld_en_n),
    .reg_clk_n(reg_clk_n), .ma_load_n(ma_load_n)
  );

  function automatic logic [1:0] m_opnd();
    if (ts == 2'd0) return 2'b11;
    if (mstate == 2'd2 && opcode == 3'd3) return 2'b11;
    return cmp_req ? 2'b00 : 2'b01;
  endfunction

  function automatic logic m_clk();
    logic t3;
    t3 = (mstate == 2'd1 && opcode == 3'd5) ||
         (mstate == 2'd0 && opcode == 3'd5 && !ind) ||
         (mstate == 2'd2 && (opcode == 3'd4 || opcode == 3'd3 ||
                             opcode == 3'd1 || opcode == 3'd0));
    return (tp1 && (mstate == 2'd0 || mstate == 2'd3)) || (tp3 && t3) ||
           (bus_strobe && iot_xfer);
  endfunction

  task automatic chk(input string req, input string what, input logic [1:0] act,
                     input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ts = 2'd1; mstate = 2'd0; opcode = 3'd7; tp1 = 0; tp3 = 0; tp4 = 0;
    bus_strobe = 0; iot_xfer = 0; ind = 0; cmp_req = 0; la_en_n = 1;
    ld_inh_n = 1; man_la = 0;
  endtask

  task automatic cycle();
    string ot;
    #1;
    ot = (ts == 2'd0) ? "R2" : (mstate == 2'd2 && opcode == 3'd3) ? "R11" : "R1";
    chk(ot, "operand", {data_ena_n, data_cmp_n}, m_opnd());
    chk("R3", "sel/carry", {sel_addr_n, carry_en_n},
        {2{~((ts == 2'd0) && la_en_n)}});
    chk("R4", "pc_ld_en_n", {1'b0, pc_ld_en_n},
        {1'b0, ~((ts == 2'd0) && la_en_n && (mstate == 2'd0 || mstate == 2'd3))});
    exp_clk_q = m_clk();
    exp_ma_q  = (tp4 && ld_inh_n) || man_la;
    clk_tag = bus_strobe ? "R9" : tp3 ? ((mstate == 2'd2) ? "R8" : "R7") :
              tp1 ? "R6" : "R10";
    @(negedge clk);
    chk(clk_tag, "reg_clk_n", {1'b0, reg_clk_n}, {1'b0, ~exp_clk_q});
    chk("R5", "ma_load_n", {1'b0, ma_load_n}, {1'b0, ~exp_ma_q});
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state of both strobes
    chk("R10", "strobes after reset", {reg_clk_n, ma_load_n}, 2'b11);

    // R9: bus strobe without IOT transfer has no effect
    idle(); bus_strobe = 1; cycle();
    idle(); bus_strobe = 1; iot_xfer = 1; cycle();
    // R8: ISZ in Execute does not clock, TAD does
    idle(); mstate = 2'd2; opcode = 3'd2; ts = 2'd2; tp3 = 1; cycle();
    idle(); mstate = 2'd2; opcode = 3'd1; ts = 2'd2; tp3 = 1; cycle();
    // R7: indirect JMP in Fetch gives no clock, Defer JMP does
    idle(); opcode = 3'd5; ind = 1; ts = 2'd2; tp3 = 1; cycle();
    idle(); mstate = 2'd1; opcode = 3'd5; ts = 2'd2; tp3 = 1; cycle();
    // R5: inhibited tp4 vs manual load
    idle(); ts = 2'd3; tp4 = 1; ld_inh_n = 0; cycle();
    idle(); ld_inh_n = 0; man_la = 1; cycle();
    // R11: Execute DCA forces zero even with complement request
    idle(); mstate = 2'd2; opcode = 3'd3; cmp_req = 1; cycle();
    // R3/R4: load-address enable blocks the step
    idle(); ts = 2'd0; la_en_n = 0; cycle();
    idle(); ts = 2'd0; mstate = 2'd3; tp1 = 1; cycle();
    // R10: single pulse returns high
    idle(); cycle();

    for (int i = 0; i < 3000; i++) begin
      ts = 2'($urandom); mstate = 2'($urandom); opcode = 3'($urandom);
      tp1 = ($urandom % 4) == 0; tp3 = ($urandom % 4) == 0;
      tp4 = ($urandom % 4) == 0; bus_strobe = ($urandom % 5) == 0;
      iot_xfer = 1'($urandom); ind = 1'($urandom); cmp_req = 1'($urandom);
      la_en_n = ($urandom % 4) != 0; ld_inh_n = ($urandom % 3) != 0;
      man_la = ($urandom % 8) == 0;
      cycle();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule